// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides, one reference cycle at a time, whether a phase-locked loop has settled. For each comparison cycle the phase detector's error pulse has already been measured as a count of fast sampling-clock ticks. The block receives that count with a one-cycle strobe. While the loop is unlocked, an error counts as good only when it is under a tight acquisition threshold. The loop is declared locked after five good evaluations in a row. Once locked, the block judges errors against a wider hold threshold and drops lock on the first evaluation that exceeds it. This hysteresis stops the flag from chattering near the edge of the window.

Two optional behaviours apply. A divide-by-4 enable presents only every fourth strobe to the evaluation, for comparison rates above about 20 MHz. A power-down input forces the lock flag low at once, without waiting for a clock edge, and restarts acquisition. A second loop's lock flag is combined with this one, so that a single output reports whether both loops are locked.

Top module: `pll_lock_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `lock_o` and `lock_all_o` are 0 and the run of good evaluations is empty.
- R2: While unlocked, an evaluated strobe is good when `err_ticks` < the acquisition threshold. `lock_o` becomes 1 at the clock edge that registers the fifth good evaluation in a row, and not before.
- R3: While unlocked, an evaluated strobe with `err_ticks` >= the acquisition threshold empties the run, so five new good evaluations are needed.
- R4: While locked, an evaluated strobe with `err_ticks` <= the hold threshold keeps `lock_o` at 1. One evaluated strobe with `err_ticks` > the hold threshold clears `lock_o` at that clock edge.
- R5: With `div4_en`=1, only the 4th, 8th, 12th, ... strobe since reset, power-down or enabling is evaluated, and the other strobes have no effect on the lock state. With `div4_en`=0, every strobe is evaluated.
- R6: `pwr_down`=1 forces `lock_o` to 0 combinationally, with no clock edge needed. While it is held, the lock state, the run and the divide-by-4 phase are cleared, so acquisition restarts from zero once it is released.
- R7: `lock_all_o` equals `lock_o` AND `peer_lock`.
- R8: The default thresholds are 10 ticks (acquisition) and 20 ticks (hold) with `SECOND_LOOP`=0, and 15 and 30 ticks with `SECOND_LOOP`=1. The hold threshold is never below the acquisition threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| err_valid | input | 1 | One-cycle strobe: a phase-error measurement is present |
| err_ticks | input | ERR_W | Phase-error pulse width in sampling ticks |
| div4_en | input | 1 | Evaluate only every fourth strobe |
| pwr_down | input | 1 | Loop powered down; forces lock low |
| peer_lock | input | 1 | Lock flag of the other loop |
| lock_o | output | 1 | Lock flag of this loop |
| lock_all_o | output | 1 | High only when both loops are locked |

## Verification
The assertions check on every cycle that the combined flag is the AND of the two lock flags and that power-down holds lock low. They also check that lock only rises right after an evaluated strobe under the acquisition threshold. Lock may fall only after a strobe above the hold threshold or during power-down. The bench scenarios are the only check on the counting behaviour. These are the exact fifth-evaluation rising edge, the emptying of the run by one bad value, and the skipped strobes under divide-by-4. The scenarios also sweep the full error range against both threshold boundaries and show that acquisition restarts after power-down.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  // Default thresholds in sampling ticks (1 tick = 1 ns at the default rate)
  localparam int ACQ_FIRST   = 10;
  localparam int HOLD_FIRST  = 20;
  localparam int ACQ_SECOND  = 15;
  localparam int HOLD_SECOND = 30;
  localparam int GOOD_RUN    = 5;
  localparam int DECIM       = 4;

  typedef enum logic {
    ST_SEEK = 1'b0,
    ST_HELD = 1'b1
  } lock_state_e;
endpackage

// File: rtl/lock_decimator.sv
module lock_decimator #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic strobe_i,
  output logic strobe_o
);
  localparam int CW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASES - 1);

  logic [CW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (clr || !en) begin
      phase_d = '0;
    end else if (strobe_i) begin
      phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign strobe_o = strobe_i && (!en || (phase_q == LAST));
endmodule

// File: rtl/lock_window_cmp.sv
module lock_window_cmp
  import pll_lock_pkg::*;
#(
  parameter int ERR_W  = 8,
  parameter int ACQ_T  = 10,
  parameter int HOLD_T = 20
) (
  input  logic [ERR_W-1:0] err_ticks,
  input  lock_state_e      state,
  output logic             pass
);
  localparam logic [ERR_W-1:0] ACQ_V  = ERR_W'(ACQ_T);
  localparam logic [ERR_W-1:0] HOLD_V = ERR_W'(HOLD_T);

  always_comb begin
    if (state == ST_HELD) pass = (err_ticks <= HOLD_V);
    else                  pass = (err_ticks <  ACQ_V);
  end
endmodule

// File: rtl/lock_state_ctl.sv
module lock_state_ctl
  import pll_lock_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        eval,
  input  logic        pass,
  output lock_state_e state
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);

  lock_state_e   state_q, state_d;
  logic [RW-1:0] run_q, run_d;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    if (clr) begin
      state_d = ST_SEEK;
      run_d   = '0;
    end else if (eval) begin
      if (state_q == ST_SEEK) begin
        if (!pass) begin
          run_d = '0;
        end else if (run_q == RUN_LAST) begin
          state_d = ST_HELD;
          run_d   = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else if (!pass) begin
        state_d = ST_SEEK;
        run_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEEK;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pll_lock_pkg::*;
#(
  parameter int ERR_W       = 8,
  parameter bit SECOND_LOOP = 1'b0,
  parameter int ACQ_T       = SECOND_LOOP ? ACQ_SECOND  : ACQ_FIRST,
  parameter int HOLD_T      = SECOND_LOOP ? HOLD_SECOND : HOLD_FIRST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_ticks,
  input  logic             div4_en,
  input  logic             pwr_down,
  input  logic             peer_lock,
  output logic             lock_o,
  output logic             lock_all_o
);
  localparam int HOLD_EFF = (HOLD_T < ACQ_T) ? ACQ_T : HOLD_T;

  logic        eval;
  logic        pass;
  lock_state_e state;

  lock_decimator #(.PHASES(DECIM)) u_decim (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pwr_down),
    .en       (div4_en),
    .strobe_i (err_valid),
    .strobe_o (eval)
  );

  lock_window_cmp #(.ERR_W(ERR_W), .ACQ_T(ACQ_T), .HOLD_T(HOLD_EFF)) u_cmp (
    .err_ticks (err_ticks),
    .state     (state),
    .pass      (pass)
  );

  lock_state_ctl #(.RUN_LEN(GOOD_RUN)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pwr_down),
    .eval  (eval),
    .pass  (pass),
    .state (state)
  );

  assign lock_o     = (state == ST_HELD) && !pwr_down;
  assign lock_all_o = lock_o && peer_lock;
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk #(
  parameter int ERR_W  = 8,
  parameter int ACQ_T  = 10,
  parameter int HOLD_T = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_valid,
  input logic [ERR_W-1:0] err_ticks,
  input logic             pwr_down,
  input logic             peer_lock,
  input logic             lock_o,
  input logic             lock_all_o
);
  localparam logic [ERR_W-1:0] ACQ_V  = ERR_W'(ACQ_T);
  localparam logic [ERR_W-1:0] HOLD_V = ERR_W'(HOLD_T);

  assert_and_combine_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_all_o == (lock_o && peer_lock));

  assert_pd_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !lock_o);

  assert_rise_needs_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> ($past(err_valid) && ($past(err_ticks) < ACQ_V) && !$past(pwr_down)));

  assert_fall_needs_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_o) && !pwr_down) |-> ($past(err_valid) && ($past(err_ticks) > HOLD_V)));

  assert_no_lock_after_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_down) |-> !lock_o);
endmodule

bind pll_lock_detect pll_lock_detect_chk #(
  .ERR_W(ERR_W), .ACQ_T(ACQ_T), .HOLD_T(HOLD_EFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ticks(err_ticks),
  .pwr_down(pwr_down), .peer_lock(peer_lock), .lock_o(lock_o), .lock_all_o(lock_all_o)
);

// File: tb/pll_lock_detect_test.sv
module pll_lock_detect_test;
  localparam int ERR_W = 8;
  localparam int ACQ   = 10;
  localparam int HOLD  = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             err_valid = 1'b0;
  logic [ERR_W-1:0] err_ticks = '0;
  logic             div4_en = 1'b0;
  logic             pwr_down = 1'b0;
  logic             peer_lock = 1'b1;
  logic             lock_o, lock_all_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pll_lock_detect uut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ticks(err_ticks),
    .div4_en(div4_en), .pwr_down(pwr_down), .peer_lock(peer_lock),
    .lock_o(lock_o), .lock_all_o(lock_all_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Present n strobes back to back with value v, then idle one cycle.
  task automatic feed(input int v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      err_valid = 1'b1;
      err_ticks = ERR_W'(v);
    end
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    pwr_down = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lock in reset", lock_o, 1'b0);
    chk("R1 all in reset", lock_all_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lock after release", lock_o, 1'b0);

    // R2/R8: acquisition threshold sweep
    for (int v = 0; v <= 40; v++) begin
      restart();
      feed(v, 4);
      chk("R2 not locked after four", lock_o, 1'b0);
      feed(v, 1);
      chk("R2 R8 lock after five", lock_o, (v < ACQ));
    end

    // R3: a bad value empties the run
    restart();
    feed(3, 4);
    feed(ACQ, 1);
    feed(3, 4);
    chk("R3 run emptied", lock_o, 1'b0);
    feed(3, 1);
    chk("R3 lock after fresh five", lock_o, 1'b1);

    // R4/R8: hold threshold sweep
    for (int v = 0; v <= 40; v++) begin
      restart();
      feed(0, 5);
      feed(v, 1);
      chk("R4 R8 hold window", lock_o, (v <= HOLD));
    end

    // R5: divide-by-4
    div4_en = 1'b1;
    restart();
    feed(1, 19);
    chk("R5 four evaluations only", lock_o, 1'b0);
    feed(1, 1);
    chk("R5 lock on 20th strobe", lock_o, 1'b1);
    feed(60, 3);
    chk("R5 skipped strobes ignored", lock_o, 1'b1);
    feed(60, 1);
    chk("R5 fourth strobe evaluated", lock_o, 1'b0);
    div4_en = 1'b0;

    // R6: asynchronous power-down and restart
    restart();
    feed(0, 5);
    chk("R6 locked before pd", lock_o, 1'b1);
    @(negedge clk);
    #1 pwr_down = 1'b1;
    #1 chk("R6 forced low without edge", lock_o, 1'b0);
    @(negedge clk);
    pwr_down = 1'b0;
    @(negedge clk);
    chk("R6 stays low after release", lock_o, 1'b0);
    feed(0, 4);
    chk("R6 acquisition restarted", lock_o, 1'b0);
    feed(0, 1);
    chk("R6 relock after five", lock_o, 1'b1);

    // R7: combined flag
    for (int p = 0; p < 2; p++) begin
      peer_lock = p[0];
      #1 chk("R7 combined locked", lock_all_o, p[0]);
    end
    restart();
    peer_lock = 1'b1;
    #1 chk("R7 combined unlocked", lock_all_o, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule